// File: doc/BRIEF.md
# Processor Reset Pulse Conditioner

This block turns an active-low raw reset request into an active-high reset for a processor whose clock is produced by a neighbouring clock generator. Every flop runs on a single reference clock. The processor clock arrives as a level on `cpu_clk_i`, and the block detects its 1-to-0 transitions as events. The reset output rises as soon as the raw request goes low. It falls only on a processor clock falling edge, and only after a guaranteed number of complete processor clock periods have passed since the request ended.

The block also works with the oscillator restart machinery. While a reset is requested and the oscillator is idle, it raises a restart request. When the oscillator is already running, including while its start-up counter is still counting, no request is raised. Processor clock edges that arrive before the clocks are declared ready are not counted. This keeps the minimum width intact after a stopped oscillator comes back.

The raw request input also serves as the block's asynchronous initialisation. It is released into the reference clock domain through a synchroniser of `SYNC_STAGES` flops (default 2).

Top module: `rst_pulse_cond`

## Requirements
- R1: While `rst_raw_n_i` is low, `cpu_reset_o` is 1 by the first sample after the input falls; at power-up (raw input low) it is 1.
- R2: `cpu_reset_o` only goes from 1 to 0 on a reference clock edge where `cpu_clk_i` is seen to change from 1 to 0; holding `cpu_clk_i` steady keeps the reset high indefinitely.
- R3: After `rst_raw_n_i` returns high and `SYNC_STAGES` reference cycles pass, the reset stays 1 through `MIN_CYCLES` (default 16) counted processor clock falling edges and drops on the next counted one (the 17th by default).
- R4: While `rst_raw_n_i` stays low, processor clock edges have no effect and `cpu_reset_o` stays 1.
- R5: `restart_req_o` is 1 whenever a reset is requested (synchronised raw input low) and `osc_run_i` is 0.
- R6: `restart_req_o` is 0 whenever `osc_run_i` is 1, so an oscillator start-up count already in progress is never disturbed.
- R7: Processor clock falling edges seen while `clk_ready_i` is 0 are not counted; the reset stays 1 and the full count starts once the clocks are ready.
- R8: A new low on `rst_raw_n_i` before release, including one in the same reference cycle as the releasing falling edge, discards the partial count; a full `MIN_CYCLES`+1 count is needed afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock, the oscillator domain |
| rst_raw_n_i | input | 1 | Raw reset request, active low, asynchronous |
| cpu_clk_i | input | 1 | Generated processor clock, sampled as a level |
| osc_run_i | input | 1 | Oscillator running (start-up count may still be in progress) |
| clk_ready_i | input | 1 | Start-up count finished, generated clocks active |
| cpu_reset_o | output | 1 | Processor reset, active high |
| restart_req_o | output | 1 | Request to start the idle oscillator |

## Verification
Two functions can act in the same reference cycle. One is the release on the counted falling edge that completes the width. The other is a fresh raw request that clears the count. The bench provokes this by driving the raw input low at the very negative edge where it lowers the processor clock for the releasing edge. The reset must then stay high, and a complete count must follow the next release before it drops. The bench also overlaps a stopped oscillator with the release. Processor edges toggled before `clk_ready_i` rises must not shorten the width, and `restart_req_o` must drop as soon as the oscillator is reported running.

// File: rtl/rst_pulse_cond_pkg.sv
package rst_pulse_cond_pkg;

  // Bits needed to hold values 0..n inclusive.
  function automatic int span_bits(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

  // Number of counted falling edges after which the release edge is accepted.
  function automatic int release_edge(input int min_cycles);
    return min_cycles + 1;
  endfunction

endpackage

// File: rtl/rst_pulse_cond_sync.sv
module rst_pulse_cond_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_n_i,
  output logic released_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  // Async clear on the raw request, ones shift in after it lifts.
  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) chain_q <= '0;
    else           chain_q <= {chain_q[LAST:0], 1'b1} >> 1 | {1'b0, chain_q[LAST:0]} << 1 | {{LAST{1'b0}}, 1'b1};
  end

  assign released_o = chain_q[LAST];
endmodule

// File: rtl/rst_pulse_cond_fall.sv
module rst_pulse_cond_fall (
  input  logic clk_i,
  input  logic arst_n_i,
  input  logic level_i,
  output logic fall_o
);
  logic level_q;

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) level_q <= 1'b0;
    else           level_q <= level_i;
  end

  assign fall_o = level_q & ~level_i;
endmodule

// File: rtl/rst_pulse_cond_span.sv
module rst_pulse_cond_span #(
  parameter int MIN_CYCLES = 16
) (
  input  logic clk_i,
  input  logic arst_n_i,
  input  logic clear_i,
  input  logic step_i,
  output logic full_o
);
  import rst_pulse_cond_pkg::*;

  localparam int W = span_bits(MIN_CYCLES);
  localparam logic [W-1:0] LIMIT = W'(MIN_CYCLES);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i)                     cnt_q <= '0;
    else if (clear_i)                  cnt_q <= '0;
    else if (step_i && cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign full_o = (cnt_q == LIMIT);
endmodule

// File: rtl/rst_pulse_cond.sv
module rst_pulse_cond #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_CYCLES  = 16
) (
  input  logic clk_i,
  input  logic rst_raw_n_i,
  input  logic cpu_clk_i,
  input  logic osc_run_i,
  input  logic clk_ready_i,
  output logic cpu_reset_o,
  output logic restart_req_o
);
  logic released;
  logic req_sync;
  logic cpu_fall;
  logic count_step;
  logic span_full;
  logic release_evt;
  logic reset_q;

  rst_pulse_cond_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .arst_n_i   (rst_raw_n_i),
    .released_o (released)
  );

  rst_pulse_cond_fall u_fall (
    .clk_i    (clk_i),
    .arst_n_i (rst_raw_n_i),
    .level_i  (cpu_clk_i),
    .fall_o   (cpu_fall)
  );

  assign req_sync   = ~released;
  assign count_step = cpu_fall & clk_ready_i & ~req_sync;

  rst_pulse_cond_span #(.MIN_CYCLES(MIN_CYCLES)) u_span (
    .clk_i    (clk_i),
    .arst_n_i (rst_raw_n_i),
    .clear_i  (req_sync),
    .step_i   (count_step),
    .full_o   (span_full)
  );

  assign release_evt = count_step & span_full;

  always_ff @(posedge clk_i or negedge rst_raw_n_i) begin
    if (!rst_raw_n_i)     reset_q <= 1'b1;
    else if (req_sync)    reset_q <= 1'b1;
    else if (release_evt) reset_q <= 1'b0;
  end

  assign cpu_reset_o   = reset_q;
  assign restart_req_o = req_sync & ~osc_run_i;
endmodule

// File: rtl/rst_pulse_cond_chk.sv
module rst_pulse_cond_chk #(
  parameter int MIN_CYCLES = 16
) (
  input logic clk_i,
  input logic rst_raw_n_i,
  input logic osc_run_i,
  input logic clk_ready_i,
  input logic cpu_reset_o,
  input logic restart_req_o,
  input logic req_sync,
  input logic cpu_fall
);
  localparam int CW = $clog2(MIN_CYCLES + 2) + 1;
  localparam logic [CW-1:0] TOP = CW'(MIN_CYCLES + 1);

  logic [CW-1:0] seen_q;

  always_ff @(posedge clk_i or negedge rst_raw_n_i) begin
    if (!rst_raw_n_i) seen_q <= '0;
    else if (req_sync) seen_q <= '0;
    else if (cpu_fall && clk_ready_i && seen_q != TOP) seen_q <= seen_q + 1'b1;
  end

  a_r2_release_on_fall: assert property (@(posedge clk_i) disable iff (!rst_raw_n_i)
    $fell(cpu_reset_o) |-> $past(cpu_fall));

  a_r3_min_width: assert property (@(posedge clk_i) disable iff (!rst_raw_n_i)
    $fell(cpu_reset_o) |-> seen_q == TOP);

  a_r4_hold_while_req: assert property (@(posedge clk_i) disable iff (!rst_raw_n_i)
    req_sync |-> cpu_reset_o);

  a_r5_request_when_idle: assert property (@(posedge clk_i) disable iff (!rst_raw_n_i)
    (req_sync && !osc_run_i) |-> restart_req_o);

  a_r6_no_disturb: assert property (@(posedge clk_i) disable iff (!rst_raw_n_i)
    osc_run_i |-> !restart_req_o);

  a_r7_no_count_unready: assert property (@(posedge clk_i) disable iff (!rst_raw_n_i)
    (cpu_reset_o && !clk_ready_i) |=> cpu_reset_o);
endmodule

bind rst_pulse_cond rst_pulse_cond_chk #(.MIN_CYCLES(MIN_CYCLES)) u_chk (
  .clk_i         (clk_i),
  .rst_raw_n_i   (rst_raw_n_i),
  .osc_run_i     (osc_run_i),
  .clk_ready_i   (clk_ready_i),
  .cpu_reset_o   (cpu_reset_o),
  .restart_req_o (restart_req_o),
  .req_sync      (req_sync),
  .cpu_fall      (cpu_fall)
);

// File: tb/rst_pulse_cond_test.sv
`timescale 1ns/1ps
module rst_pulse_cond_test;
  localparam int MINC = 16;

  logic clk = 1'b0;
  logic raw_n = 1'b0;
  logic cpu = 1'b0;
  logic osc = 1'b0;
  logic rdy = 1'b0;
  logic rst_o;
  logic rreq_o;

  rst_pulse_cond #(.SYNC_STAGES(2), .MIN_CYCLES(MINC)) uut (
    .clk_i         (clk),
    .rst_raw_n_i   (raw_n),
    .cpu_clk_i     (cpu),
    .osc_run_i     (osc),
    .clk_ready_i   (rdy),
    .cpu_reset_o   (rst_o),
    .restart_req_o (rreq_o)
  );

  always #4 clk = ~clk;

  typedef struct {
    int    due;
    bit    rst;
    bit    req;
    string tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // Monitor: pops expectations once their cycle has come.
  always @(posedge clk) begin
    cyc = cyc + 1;
    #1;
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      n_checks++;
      if (rst_o !== e.rst || rreq_o !== e.req) begin
        n_fail++;
        $display("FAIL %s: cpu_reset=%b restart_req=%b expected cpu_reset=%b restart_req=%b",
                 e.tag, rst_o, rreq_o, e.rst, e.req);
      end
    end
  end

  // Driver side: expected restart request follows R5/R6 from the inputs.
  task automatic expect_out(input bit r, input string tag);
    exp_t e;
    e.due = cyc + 1;
    e.rst = r;
    e.req = (!raw_n && !osc);
    e.tag = tag;
    q.push_back(e);
  endtask

  // One processor clock period: high one reference cycle, low two.
  task automatic cpu_cycle(input bit r_after, input string tag);
    cpu = 1'b1;
    @(negedge clk);
    cpu = 1'b0;
    expect_out(r_after, tag);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic release_raw();
    cpu = 1'b1;
    raw_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic full_release(input string tag);
    for (int i = 0; i < MINC; i++) cpu_cycle(1'b1, tag);
    cpu_cycle(1'b0, tag);
  endtask

  initial begin
    @(negedge clk);
    expect_out(1'b1, "R1 power-up reset high");
    @(negedge clk);
    expect_out(1'b1, "R5 restart request while idle");
    repeat (3) @(negedge clk);
    osc = 1'b1;
    expect_out(1'b1, "R6 no request while start-up count runs");
    repeat (4) @(negedge clk);
    rdy = 1'b1;
    for (int i = 0; i < 20; i++) cpu_cycle(1'b1, "R4 held while raw low");

    // Main release with a pause of the processor clock before the last edge.
    release_raw();
    for (int i = 0; i < MINC; i++) cpu_cycle(1'b1, "R3 width not yet reached");
    cpu = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      expect_out(1'b1, "R2 no release without falling edge");
    end
    cpu_cycle(1'b0, "R3 release on 17th edge");
    repeat (3) @(negedge clk);
    expect_out(1'b0, "R3 stays released");

    // Reassert, then reload by a short pulse mid-count.
    @(negedge clk);
    cpu = 1'b1;
    raw_n = 1'b0;
    expect_out(1'b1, "R1 reassert after release");
    repeat (2) @(negedge clk);
    release_raw();
    for (int i = 0; i < 10; i++) cpu_cycle(1'b1, "R8 partial count");
    raw_n = 1'b0;
    @(negedge clk);
    release_raw();
    full_release("R8 full count after reload");

    // Collision: new request in the cycle of the releasing edge.
    @(negedge clk);
    raw_n = 1'b0;
    expect_out(1'b1, "R1 reassert");
    repeat (2) @(negedge clk);
    release_raw();
    for (int i = 0; i < MINC; i++) cpu_cycle(1'b1, "R8 count before collision");
    cpu = 1'b1;
    @(negedge clk);
    cpu = 1'b0;
    raw_n = 1'b0;
    expect_out(1'b1, "R8 reload wins over release");
    @(negedge clk);
    release_raw();
    full_release("R8 full count after collision");

    // Stopped oscillator: edges before clocks ready do not count.
    @(negedge clk);
    raw_n = 1'b0;
    osc = 1'b0;
    rdy = 1'b0;
    @(negedge clk);
    expect_out(1'b1, "R5 request with stopped oscillator");
    @(negedge clk);
    osc = 1'b1;
    expect_out(1'b1, "R6 request drops once oscillator runs");
    @(negedge clk);
    release_raw();
    for (int i = 0; i < 12; i++) cpu_cycle(1'b1, "R7 edges ignored before ready");
    cpu = 1'b1;
    @(negedge clk);
    rdy = 1'b1;
    full_release("R7 full count after clocks ready");

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, got no finish expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule